// File: doc/BRIEF.md
# Byte-Packing DMA Bridge with Bus Arbitration

This block lets an 8-bit peripheral stream bytes to or from a 32-bit memory bus without the CPU touching each byte. Bytes travel through a four-lane latch. In one direction, bytes from the peripheral are packed into a longword and then written to memory. In the other direction, a longword is read from memory and then handed to the peripheral one byte at a time. To move each longword, the block requests the bus, waits for the grant, takes ownership with its own grant-acknowledge, runs a single bus cycle and then releases the bus.

The CPU sets up a transfer in four steps:
1. Write the start address into the address counter.
2. Write the direction bit into the control register.
3. Write the enable bit in a separate access.
4. To finish, read any bytes left in the latch and then clear the enable bit.

The start address may be unaligned. In that case only the first bus cycle carries the true low address bits and a matching size, so that memory bytes below the start address are never written. Every later cycle is an aligned longword.

The peripheral side is a valid/ready pair:
- The peripheral holds `p_valid` while it wants a byte moved, and a byte moves on every clock edge where `p_valid` and `p_ready` are both high.
- `p_ready` does not depend on `p_valid`. It applies back-pressure: it is low while the block is disabled, while a longword request is pending, and while the block owns or is requesting the bus.
- The peripheral keeps `p_wdata` stable while `p_valid` is high and not yet accepted.

Top module: `pdma_bridge`

## Requirements
- R1: After reset, all of the following are low: bus request, grant-acknowledge, both strobes and `p_ready`. The control register reads back as zero.
- R2: Register select codes:
  - `reg_sel` 0 is the address counter. It is written and read as a full 32-bit value, and its low two bits become the starting byte lane.
  - `reg_sel` 1 is control.
  - `reg_sel` 2 is the byte latch.
- R3: With direction 0 (peripheral to memory), each accepted byte is placed into the current lane. Lane k occupies bits [31-8k:24-8k] (lane 0 is most significant). The bus cycle is a write (`m_we`=1) that drives the latch on `m_wdata`.
- R4: A byte accepted in lane 3 raises a longword request. `p_ready` stays low while that request is pending or a bus cycle is running, and it is never high while the block requests or owns the bus.
- R5: Bus request rules:
  - The bus request rises only when no other master holds grant-acknowledge.
  - The bus request drops when the block's own grant-acknowledge asserts.
  - `bg_pass` follows `bg_in` only while the block neither requests nor owns the bus.
- R6: A bus cycle starts (grant-acknowledge and address strobe rise) only when all of the following held in the cycle before: the grant is high, the other master's acknowledge is low, and termination is low.
- R7: Strobe sequence:
  - The address strobe asserts first.
  - The data strobe follows one cycle later.
  - Both strobes and grant-acknowledge drop on the edge that samples `m_ack` high during the data phase.
- R8: Address and size on the bus:
  - The first cycle after an address load drives the loaded address and size (4 - a[1:0]) mod 4, where size 0 = 4 bytes, 1 = 1 byte, 2 = 2 bytes and 3 = 3 bytes.
  - Later cycles drive bits [1:0] = 0 and size 0.
- R9: After each completed bus cycle, the address counter advances to the next aligned longword.
- R10: Memory-to-peripheral prefetch:
  - With direction 1, setting enable immediately requests a read.
  - The read data fills the latch.
  - The peripheral then receives the bytes on `p_rdata`, in lane order, starting at the loaded lane.
- R11: A CPU read of the latch returns the bytes packed so far.
- R12: Clearing enable has these effects:
  - It withdraws any pending request and drops the bus request before any grant is taken.
  - It holds `p_ready` low.
  - A bus cycle already running completes normally.
- R13: The control register keeps direction in bit 0 (1 = memory to peripheral) and enable in bit 1, and reads back both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | CPU register select (0 address, 1 control, 2 latch) |
| reg_we | input | 1 | CPU write strobe |
| reg_wdata | input | 32 | CPU write data |
| reg_rdata | output | 32 | CPU read data for the selected register |
| p_valid | input | 1 | Peripheral wants a byte moved |
| p_wdata | input | 8 | Byte from the peripheral |
| p_rdata | output | 8 | Byte to the peripheral |
| p_ready | output | 1 | Block accepts or supplies a byte this cycle |
| br_out | output | 1 | Bus request |
| bg_in | input | 1 | Bus grant |
| bgack_in | input | 1 | Another master holds the bus |
| bgack_out | output | 1 | This block holds the bus |
| bg_pass | output | 1 | Grant passed to downstream masters |
| m_addr | output | 32 | Bus address |
| m_size | output | 2 | Transfer size (0 = 4 bytes) |
| m_as | output | 1 | Address strobe |
| m_ds | output | 1 | Data strobe |
| m_we | output | 1 | Write cycle |
| m_wdata | output | 32 | Write data |
| m_rdata | input | 32 | Read data |
| m_ack | input | 1 | Cycle termination |

## Verification
The embedded properties watch the bus handshake on every cycle:
- the bus request never rises while another master holds the bus;
- the block takes ownership only under the grant conditions;
- the data strobe always follows the address strobe;
- termination releases strobes and ownership together;
- the grant is never passed on while the block requests or owns the bus;
- the peripheral is never offered a transfer while the bus is busy.

Only the bench scenarios can show the byte-level results: lane placement, alignment and size of the first cycle against later ones, counter advance and carry, the prefetch order in the read direction, the leftover latch contents, and abort before and during a cycle.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
  typedef enum logic [1:0] {
    SEL_ADDR  = 2'd0,
    SEL_CTRL  = 2'd1,
    SEL_LATCH = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_AS   = 2'd2,
    ST_DS   = 2'd3
  } seq_st_e;

  localparam int CTRL_DIR_BIT = 0;
  localparam int CTRL_EN_BIT  = 1;
endpackage

// File: rtl/pdma_regs.sv
module pdma_regs
  import pdma_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int LANE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [BUS_W-1:0]  reg_wdata,
  input  logic              cyc_done,
  output logic [BUS_W-1:0]  ctr,
  output logic [LANE_W-1:0] start_lane,
  output logic              first,
  output logic              dir,
  output logic              en,
  output logic              addr_load,
  output logic              en_rise_m2p,
  output logic              en_clear
);
  reg_sel_e sel;
  logic     wr_ctrl;

  assign sel         = reg_sel_e'(reg_sel);
  assign addr_load   = reg_we && (sel == SEL_ADDR);
  assign wr_ctrl     = reg_we && (sel == SEL_CTRL);
  assign en_rise_m2p = wr_ctrl && reg_wdata[CTRL_EN_BIT] && reg_wdata[CTRL_DIR_BIT] && !en;
  assign en_clear    = wr_ctrl && !reg_wdata[CTRL_EN_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctr        <= '0;
      start_lane <= '0;
      first      <= 1'b1;
    end else if (addr_load) begin
      ctr        <= reg_wdata;
      start_lane <= reg_wdata[LANE_W-1:0];
      first      <= 1'b1;
    end else if (cyc_done) begin
      ctr   <= {ctr[BUS_W-1:LANE_W] + 1'b1, {LANE_W{1'b0}}};
      first <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir <= 1'b0;
      en  <= 1'b0;
    end else if (wr_ctrl) begin
      dir <= reg_wdata[CTRL_DIR_BIT];
      en  <= reg_wdata[CTRL_EN_BIT];
    end
  end

  AST_FIRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_done && !addr_load) |=> !first); // R8
endmodule

// File: rtl/pdma_pack.sv
module pdma_pack #(
  parameter int BUS_W  = 32,
  parameter int BYTE_W = 8,
  localparam int LANES  = BUS_W / BYTE_W,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              dir,
  input  logic              addr_load,
  input  logic [LANE_W-1:0] load_lane,
  input  logic              en_rise_m2p,
  input  logic              en_clear,
  input  logic              bus_idle,
  input  logic              cyc_done,
  input  logic [BUS_W-1:0]  m_rdata,
  input  logic              cpu_latch_we,
  input  logic [BUS_W-1:0]  cpu_wdata,
  input  logic              p_valid,
  input  logic [BYTE_W-1:0] p_wdata,
  output logic [BYTE_W-1:0] p_rdata,
  output logic              p_ready,
  output logic [BUS_W-1:0]  latch,
  output logic              rq
);
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

  logic [LANES-1:0][BYTE_W-1:0] lb;
  logic [LANE_W-1:0]            lane;
  logic [LANE_W-1:0]            slot;
  logic                         fire;
  logic                         last;

  assign p_ready = en && !rq && bus_idle;
  assign fire    = p_valid && p_ready;
  assign last    = (lane == LAST_LANE);
  assign slot    = LAST_LANE - lane;
  assign p_rdata = lb[slot];
  assign latch   = lb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         lane <= '0;
    else if (addr_load) lane <= load_lane;
    else if (fire)      lane <= lane + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              rq <= 1'b0;
    else if (en_clear)       rq <= 1'b0;
    else if (en_rise_m2p)    rq <= 1'b1;
    else if (cyc_done)       rq <= 1'b0;
    else if (fire && last)   rq <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lb <= '0;
    end else if (cpu_latch_we) begin
      lb <= cpu_wdata;
    end else if (cyc_done && dir) begin
      lb <= m_rdata;
    end else if (fire && !dir) begin
      for (int k = 0; k < LANES; k++) begin
        if (slot == LANE_W'(k)) lb[k] <= p_wdata;
      end
    end
  end

  AST_RQ_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && last && !en_clear && !en_rise_m2p) |=> rq); // R4
endmodule

// File: rtl/pdma_master.sv
module pdma_master
  import pdma_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic want,
  input  logic en,
  input  logic bg_in,
  input  logic bgack_in,
  input  logic m_ack,
  output logic br_out,
  output logic bgack_out,
  output logic bg_pass,
  output logic m_as,
  output logic m_ds,
  output logic cyc_done,
  output logic bus_idle
);
  seq_st_e st;

  assign cyc_done = (st == ST_DS) && m_ack;
  assign bus_idle = (st == ST_IDLE);
  assign bg_pass  = bg_in && !br_out && !bgack_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      br_out    <= 1'b0;
      bgack_out <= 1'b0;
      m_as      <= 1'b0;
      m_ds      <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (want && !bgack_in) begin
          br_out <= 1'b1;
          st     <= ST_REQ;
        end
        ST_REQ: if (!en) begin
          br_out <= 1'b0;
          st     <= ST_IDLE;
        end else if (bg_in && !bgack_in && !m_ack) begin
          br_out    <= 1'b0;
          bgack_out <= 1'b1;
          m_as      <= 1'b1;
          st        <= ST_AS;
        end
        ST_AS: begin
          m_ds <= 1'b1;
          st   <= ST_DS;
        end
        ST_DS: if (m_ack) begin
          m_as      <= 1'b0;
          m_ds      <= 1'b0;
          bgack_out <= 1'b0;
          st        <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_BR_FREE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(br_out) |-> !$past(bgack_in)); // R5
  AST_BR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    bgack_out |-> !br_out); // R5
  AST_PASS_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    bg_pass |-> (!br_out && !bgack_out)); // R5
  AST_GRANT_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bgack_out) |-> ($past(bg_in) && !$past(bgack_in) && !$past(m_ack))); // R6
  AST_DS_AFTER_AS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_ds) |-> ($past(m_as) && m_as)); // R7
  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (m_ds && m_ack) |=> (!m_as && !m_ds && !bgack_out)); // R7
endmodule

// File: rtl/pdma_bridge.sv
module pdma_bridge
  import pdma_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int BYTE_W = 8,
  localparam int LANES  = BUS_W / BYTE_W,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_sel,
  input  logic              reg_we,
  input  logic [BUS_W-1:0]  reg_wdata,
  output logic [BUS_W-1:0]  reg_rdata,
  input  logic              p_valid,
  input  logic [BYTE_W-1:0] p_wdata,
  output logic [BYTE_W-1:0] p_rdata,
  output logic              p_ready,
  output logic              br_out,
  input  logic              bg_in,
  input  logic              bgack_in,
  output logic              bgack_out,
  output logic              bg_pass,
  output logic [BUS_W-1:0]  m_addr,
  output logic [LANE_W-1:0] m_size,
  output logic              m_as,
  output logic              m_ds,
  output logic              m_we,
  output logic [BUS_W-1:0]  m_wdata,
  input  logic [BUS_W-1:0]  m_rdata,
  input  logic              m_ack
);
  logic [BUS_W-1:0]  ctr;
  logic [BUS_W-1:0]  latch;
  logic [LANE_W-1:0] start_lane;
  logic first, dir, en, addr_load, en_rise_m2p, en_clear;
  logic rq, cyc_done, bus_idle, cpu_latch_we;

  assign cpu_latch_we = reg_we && (reg_sel_e'(reg_sel) == SEL_LATCH);

  pdma_regs #(.BUS_W(BUS_W), .LANE_W(LANE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .cyc_done(cyc_done), .ctr(ctr),
    .start_lane(start_lane), .first(first), .dir(dir), .en(en),
    .addr_load(addr_load), .en_rise_m2p(en_rise_m2p), .en_clear(en_clear)
  );

  pdma_pack #(.BUS_W(BUS_W), .BYTE_W(BYTE_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .en(en), .dir(dir), .addr_load(addr_load),
    .load_lane(reg_wdata[LANE_W-1:0]), .en_rise_m2p(en_rise_m2p),
    .en_clear(en_clear), .bus_idle(bus_idle), .cyc_done(cyc_done),
    .m_rdata(m_rdata), .cpu_latch_we(cpu_latch_we), .cpu_wdata(reg_wdata),
    .p_valid(p_valid), .p_wdata(p_wdata), .p_rdata(p_rdata),
    .p_ready(p_ready), .latch(latch), .rq(rq)
  );

  pdma_master u_master (
    .clk(clk), .rst_n(rst_n), .want(rq && en), .en(en), .bg_in(bg_in),
    .bgack_in(bgack_in), .m_ack(m_ack), .br_out(br_out),
    .bgack_out(bgack_out), .bg_pass(bg_pass), .m_as(m_as), .m_ds(m_ds),
    .cyc_done(cyc_done), .bus_idle(bus_idle)
  );

  assign m_addr  = first ? ctr : {ctr[BUS_W-1:LANE_W], {LANE_W{1'b0}}};
  assign m_size  = first ? (~start_lane + 1'b1) : '0;
  assign m_we    = !dir;
  assign m_wdata = latch;

  always_comb begin
    unique case (reg_sel_e'(reg_sel))
      SEL_ADDR:  reg_rdata = ctr;
      SEL_CTRL:  reg_rdata = {{(BUS_W-2){1'b0}}, en, dir};
      SEL_LATCH: reg_rdata = latch;
      default:   reg_rdata = '0;
    endcase
  end

  AST_READY_OFF_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    p_ready |-> (!m_as && !bgack_out && !br_out)); // R4
endmodule

// File: tb/test_pdma_bridge.sv
module test_pdma_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_sel = 2'd3;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        p_valid = 1'b0;
  logic [7:0]  p_wdata = '0;
  logic [7:0]  p_rdata;
  logic        p_ready, br_out, bgack_out, bg_pass, m_as, m_ds, m_we;
  logic        bg_in = 1'b0, bgack_in = 1'b0, m_ack = 1'b0;
  logic [31:0] m_addr, m_wdata;
  logic [31:0] m_rdata = '0;
  logic [1:0]  m_size;
  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  pdma_bridge i_pdma_bridge (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .p_valid(p_valid),
    .p_wdata(p_wdata), .p_rdata(p_rdata), .p_ready(p_ready),
    .br_out(br_out), .bg_in(bg_in), .bgack_in(bgack_in),
    .bgack_out(bgack_out), .bg_pass(bg_pass), .m_addr(m_addr),
    .m_size(m_size), .m_as(m_as), .m_ds(m_ds), .m_we(m_we),
    .m_wdata(m_wdata), .m_rdata(m_rdata), .m_ack(m_ack)
  );

  localparam logic [31:0] VEC_ADDR [0:3] = '{32'h1000_0000, 32'h2345_6781,
                                             32'h0000_00FE, 32'h7FFF_FFFB};
  localparam logic [1:0]  VEC_SIZE [0:3] = '{2'd0, 2'd3, 2'd2, 2'd1};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] s, input logic [31:0] d);
    reg_sel = s; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0; reg_sel = 2'd3;
  endtask

  task automatic reg_rd(input logic [1:0] s, output logic [31:0] d);
    reg_sel = s; #1; d = reg_rdata; reg_sel = 2'd3;
  endtask

  task automatic push(input logic [7:0] b);
    p_valid = 1'b1; p_wdata = b; #1;
    while (!p_ready) begin @(negedge clk); #1; end
    @(posedge clk); @(negedge clk);
    p_valid = 1'b0;
  endtask

  task automatic pull(output logic [7:0] b);
    p_valid = 1'b1; #1;
    while (!p_ready) begin @(negedge clk); #1; end
    b = p_rdata;
    @(posedge clk); @(negedge clk);
    p_valid = 1'b0;
  endtask

  task automatic serve(input logic [31:0] rd, output logic [31:0] a,
                       output logic [1:0] s, output logic we, output logic [31:0] wd);
    while (!br_out) @(negedge clk);
    bg_in = 1'b1;
    while (!m_ds) @(negedge clk);
    chk("R7 address strobe held with data strobe", {31'd0, m_as}, 32'd1);
    chk("R6 ownership during cycle", {31'd0, bgack_out}, 32'd1);
    a = m_addr; s = m_size; we = m_we; wd = m_wdata;
    m_ack = 1'b1; m_rdata = rd;
    @(negedge clk);
    m_ack = 1'b0; bg_in = 1'b0;
    chk("R7 release after termination", {29'd0, m_as, m_ds, bgack_out}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] a, wd, rv, exp, mask, base;
    logic [1:0]  s;
    logic        we;
    logic [7:0]  b;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    p_valid = 1'b1; #1;
    chk("R1 reset idle outputs", {27'd0, br_out, bgack_out, m_as, m_ds, p_ready}, 32'd0);
    p_valid = 1'b0;
    reg_rd(2'd1, rv);
    chk("R1 control reset value", rv, 32'd0);

    // R13: direction only, then readback
    reg_wr(2'd1, 32'h1);
    reg_rd(2'd1, rv);
    chk("R13 control readback", rv, 32'h1);
    reg_wr(2'd1, 32'h0);

    // R2: address readback
    reg_wr(2'd0, 32'hDEAD_BEEF);
    reg_rd(2'd0, rv);
    chk("R2 address readback", rv, 32'hDEAD_BEEF);

    // Table walk: peripheral to memory, aligned and unaligned bases
    for (int i = 0; i < 4; i++) begin
      base = VEC_ADDR[i];
      reg_wr(2'd0, base);
      reg_wr(2'd1, 32'h2);
      exp = '0; mask = '0;
      for (int ln = int'(base[1:0]); ln < 4; ln++) begin
        b = 8'(16 * i + ln + 1);
        push(b);
        exp[31 - 8*ln -: 8] = b;
        mask[31 - 8*ln -: 8] = 8'hFF;
      end
      #1;
      chk("R4 ready low with request pending", {31'd0, p_ready}, 32'd0);
      serve(32'd0, a, s, we, wd);
      chk("R8 first address", a, base);
      chk("R8 first size", {30'd0, s}, {30'd0, VEC_SIZE[i]});
      chk("R3 write cycle", {31'd0, we}, 32'd1);
      chk("R3 packed lanes", wd & mask, exp);
      for (int ln = 0; ln < 4; ln++) begin
        b = 8'(8'hA0 + ln + i);
        push(b);
        exp[31 - 8*ln -: 8] = b;
      end
      serve(32'd0, a, s, we, wd);
      chk("R8 later address aligned", a, {base[31:2] + 30'd1, 2'b00});
      chk("R8 later size longword", {30'd0, s}, 32'd0);
      chk("R3 full longword", wd, exp);
      reg_rd(2'd0, rv);
      chk("R9 counter advance", rv, {base[31:2] + 30'd2, 2'b00});
      reg_wr(2'd1, 32'h0);
    end

    // R5/R6: another master holds the bus
    reg_wr(2'd0, 32'h0000_0600);
    reg_wr(2'd1, 32'h2);
    bgack_in = 1'b1; bg_in = 1'b1;
    for (int k = 0; k < 4; k++) push(8'(k));
    repeat (4) @(negedge clk);
    chk("R5 no request while bus held", {31'd0, br_out}, 32'd0);
    chk("R6 no ownership while bus held", {31'd0, bgack_out}, 32'd0);
    chk("R5 grant passed when idle", {31'd0, bg_pass}, 32'd1);
    bgack_in = 1'b0; bg_in = 1'b0;
    while (!br_out) @(negedge clk);
    bg_in = 1'b1; #1;
    chk("R5 grant blocked while requesting", {31'd0, bg_pass}, 32'd0);
    serve(32'd0, a, s, we, wd);
    chk("R6 cycle after release", a, 32'h0000_0600);
    reg_wr(2'd1, 32'h0);

    // R11: leftover bytes visible to the CPU
    reg_wr(2'd0, 32'h0000_0700);
    reg_wr(2'd1, 32'h2);
    push(8'hAB); push(8'hCD);
    reg_rd(2'd2, rv);
    chk("R11 leftover latch", {16'd0, rv[31:16]}, 32'h0000_ABCD);
    reg_wr(2'd1, 32'h0);
    p_valid = 1'b1; #1;
    chk("R12 ready low when disabled", {31'd0, p_ready}, 32'd0);
    p_valid = 1'b0;

    // R12: abort before grant
    reg_wr(2'd0, 32'h0000_0800);
    reg_wr(2'd1, 32'h2);
    for (int k = 0; k < 4; k++) push(8'(k));
    bg_in = 1'b1;
    reg_wr(2'd1, 32'h0);
    @(negedge clk);
    chk("R12 request withdrawn", {31'd0, br_out}, 32'd0);
    repeat (3) @(negedge clk);
    chk("R12 no cycle after abort", {30'd0, bgack_out, m_as}, 32'd0);
    bg_in = 1'b0;

    // R12: disable during a running cycle
    reg_wr(2'd0, 32'h0000_0900);
    reg_wr(2'd1, 32'h2);
    for (int k = 0; k < 4; k++) push(8'(k));
    while (!br_out) @(negedge clk);
    bg_in = 1'b1;
    while (!m_as) @(negedge clk);
    reg_wr(2'd1, 32'h0);
    chk("R12 running cycle continues", {31'd0, m_ds}, 32'd1);
    m_ack = 1'b1;
    @(negedge clk);
    m_ack = 1'b0; bg_in = 1'b0;
    chk("R12 bus released after cycle", {30'd0, bgack_out, m_as}, 32'd0);

    // R10: memory to peripheral with prefetch
    reg_wr(2'd0, 32'h4000_0001);
    reg_wr(2'd1, 32'h1);
    reg_wr(2'd1, 32'h3);
    #1;
    chk("R10 ready low during prefetch", {31'd0, p_ready}, 32'd0);
    serve(32'hA1B2_C3D4, a, s, we, wd);
    chk("R10 prefetch address", a, 32'h4000_0001);
    chk("R10 prefetch size", {30'd0, s}, 32'd3);
    chk("R10 read cycle", {31'd0, we}, 32'd0);
    pull(b); chk("R10 byte lane 1", {24'd0, b}, 32'hB2);
    pull(b); chk("R10 byte lane 2", {24'd0, b}, 32'hC3);
    pull(b); chk("R10 byte lane 3", {24'd0, b}, 32'hD4);
    serve(32'h1122_3344, a, s, we, wd);
    chk("R8 next read aligned", a, 32'h4000_0004);
    chk("R8 next read size", {30'd0, s}, 32'd0);
    pull(b); chk("R10 next lane 0", {24'd0, b}, 32'h11);
    pull(b); chk("R10 next lane 1", {24'd0, b}, 32'h22);
    reg_rd(2'd0, rv);
    chk("R9 counter after reads", rv, 32'h4000_0008);
    reg_wr(2'd1, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule